// File: doc/BRIEF.md
# DRAM Bank-Extension Glue

This block sits beside a DRAM expansion controller that can only address 512 KB and lets the same controller reach up to 2 MB. It adds a hidden two-bit group-select register to the host's I/O page. The register shares an offset with the controller's own bank register and takes the data bits that the controller ignores. The selected group is one of four 512 KB slices of memory. The block steers the controller's two active-low column strobes to the pair of chip-group CAS lines that belongs to that slice. Row strobes are not steered: every DRAM group still receives the shared RAS, so RAS-only refresh keeps covering all installed memory. The row strobe therefore does not pass through this block.

Software sees the extra memory as more 64 KB banks. The effective bank number is the group select above the controller's three bank bits, which gives banks 0 to 31. The controller wraps a transfer at the end of its 512 KB space, so a transfer that runs past the top of a group restarts at the base of that same group. The register cannot be read back. When software reads the shared offset, the controller's own register answers and this block stays off the bus.

An active-low compatibility input clears the register asynchronously and holds it at zero. The block then behaves exactly like an unextended 512 KB unit. A two-bit status output mirrors the register so that two indicator LEDs can show the active group in binary.

Top module: `bx_bank_ext`

## Requirements
- R1: A write cycle has the I/O page select low, host_rw low (0 = write) and host_addr[2:0] equal to 6. The register captures on the falling edge of phi2 that ends such a cycle, and grp_led shows the new value after that edge.
- R2: Only host_addr[2:0] is decoded, so writes at offsets 0x0E, 0x16, 0x1E and 0x86 load the register just as offset 0x06 does.
- R3: host_data bit 3 becomes select bit 0 and host_data bit 4 becomes select bit 1. Data bits 0 to 2 and 5 to 7 have no effect on the register.
- R4: The register keeps its value on a read cycle (host_rw high) at offset 6, on a write to any offset whose low three bits differ from 6, and on a write while io_page_n is high.
- R5: While compat_clr_n is low, the register is zero immediately, without waiting for a clock edge. It stays zero through any write, and it remains zero after release until the next qualified write.
- R6: ctl_cas_n[0] appears on bank_cas_n[2*sel] and ctl_cas_n[1] on bank_cas_n[2*sel+1], following the strobe level combinationally. Here sel is the register value.
- R7: Every bank_cas_n line outside the selected pair stays high, whatever the strobe inputs do.
- R8: grp_led always equals the register value, with grp_led[1] as select bit 1.
- R9: After rst_n is pulsed low, the register is zero and all eight bank_cas_n lines are high while both controller strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Host phase-2 clock; the register captures on its falling edge |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| compat_clr_n | input | 1 | Active-low compatibility clear; holds the register at zero |
| io_page_n | input | 1 | Active-low select of the host I/O page |
| host_addr | input | 8 | Offset within the I/O page |
| host_rw | input | 1 | Host direction, 1 = read, 0 = write |
| host_data | input | 8 | Host data bus (only bits 4:3 are used) |
| ctl_cas_n | input | 2 | Column strobes from the DRAM controller, active low |
| bank_cas_n | output | 8 | Column strobes to the eight chip groups, active low |
| grp_led | output | 2 | Active 512 KB group, in binary, for indicators |

## Verification
The bound checker checks the strobe routing on every phi2 cycle. It checks that the selected pair carries the controller's strobes and that no more CAS lines are low than the controller asserts. On every edge it also checks that a qualified write loads the register, that a cycle without a write leaves the register unchanged, and that an active clear holds the status at zero. Only the bench scenarios can show that the address aliases, the data-bit positions and a clear raised between two edges behave as required. The same holds for all sixteen combinations of group and strobe pattern. For these, the bench's behavioural model predicts the outputs and the bench compares them with the design on every clock.

// File: rtl/bx_pkg.sv
`timescale 1ns/1ps
package bx_pkg;
  // Host-side decode
  localparam int BX_ADDR_W   = 8;  // I/O page offset width
  localparam int BX_DEC_W    = 3;  // offset bits actually decoded
  localparam int BX_MATCH    = 6;  // decoded offset of the shared bank register
  localparam int BX_DATA_W   = 8;  // host data bus width
  localparam int BX_DATA_LO  = 3;  // lowest data bit captured
  // DRAM side
  localparam int BX_SEL_W    = 2;  // group-select width (four 512 KB slices)
  localparam int BX_CAS_PER  = 2;  // controller CAS strobes per slice
endpackage

// File: rtl/bx_wr_decode.sv
`timescale 1ns/1ps
module bx_wr_decode #(
  parameter int ADDR_W = 8,
  parameter int DEC_W  = 3,
  parameter int MATCH  = 6
) (
  input  logic              io_page_n,
  input  logic              host_rw,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              wr_hit
);
  localparam logic [ADDR_W-1:0] DEC_MASK  = ADDR_W'((1 << DEC_W) - 1);
  localparam logic [ADDR_W-1:0] MATCH_OFF = ADDR_W'(MATCH);

  // Offset compare modulo 2**DEC_W: upper bits are masked away, giving aliases.
  function automatic logic offset_hits(input logic [ADDR_W-1:0] off);
    return ((off ^ MATCH_OFF) & DEC_MASK) == '0;
  endfunction

  assign wr_hit = ~io_page_n & ~host_rw & offset_hits(host_addr);
endmodule

// File: rtl/bx_sel_reg.sv
`timescale 1ns/1ps
module bx_sel_reg #(
  parameter int SEL_W   = 2,
  parameter int DATA_W  = 8,
  parameter int DATA_LO = 3
) (
  input  logic              phi2,
  input  logic              clr_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] host_data,
  output logic [SEL_W-1:0]  sel
);
  // Field extraction: bits DATA_LO upward become the select value.
  function automatic logic [SEL_W-1:0] pick_field(input logic [DATA_W-1:0] d);
    return SEL_W'(d >> DATA_LO);
  endfunction

  always_ff @(negedge phi2 or negedge clr_n) begin
    if (!clr_n) begin
      sel <= '0;
    end else if (wr_hit) begin
      sel <= pick_field(host_data);
    end
  end
endmodule

// File: rtl/bx_cas_steer.sv
`timescale 1ns/1ps
module bx_cas_steer #(
  parameter int SEL_W = 2,
  parameter int CPG   = 2,
  parameter int NOUT  = (1 << SEL_W) * CPG
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [CPG-1:0]   ctl_cas_n,
  output logic [NOUT-1:0]  bank_cas_n
);
  localparam int NGRP = 1 << SEL_W;

  function automatic logic grp_on(input logic [SEL_W-1:0] s, input int g);
    return s == SEL_W'(g);
  endfunction

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar k = 0; k < CPG; k++) begin : g_strobe
      assign bank_cas_n[g*CPG + k] = grp_on(sel, g) ? ctl_cas_n[k] : 1'b1;
    end
  end
endmodule

// File: rtl/bx_bank_ext.sv
`timescale 1ns/1ps
module bx_bank_ext
  import bx_pkg::*;
#(
  parameter int ADDR_W  = BX_ADDR_W,
  parameter int DEC_W   = BX_DEC_W,
  parameter int MATCH   = BX_MATCH,
  parameter int DATA_W  = BX_DATA_W,
  parameter int DATA_LO = BX_DATA_LO,
  parameter int SEL_W   = BX_SEL_W,
  parameter int CPG     = BX_CAS_PER
) (
  input  logic                          phi2,
  input  logic                          rst_n,
  input  logic                          compat_clr_n,
  input  logic                          io_page_n,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic                          host_rw,
  input  logic [DATA_W-1:0]             host_data,
  input  logic [CPG-1:0]                ctl_cas_n,
  output logic [(1<<SEL_W)*CPG-1:0]     bank_cas_n,
  output logic [SEL_W-1:0]              grp_led
);
  localparam int NOUT = (1 << SEL_W) * CPG;

  logic             clr_all_n;  // power-up reset or compatibility clear
  logic             wr_hit;     // qualified write to the shared offset
  logic [SEL_W-1:0] sel;        // group-select register

  assign clr_all_n = rst_n & compat_clr_n;

  bx_wr_decode #(.ADDR_W(ADDR_W), .DEC_W(DEC_W), .MATCH(MATCH)) u_dec (
    .io_page_n (io_page_n),
    .host_rw   (host_rw),
    .host_addr (host_addr),
    .wr_hit    (wr_hit)
  );

  bx_sel_reg #(.SEL_W(SEL_W), .DATA_W(DATA_W), .DATA_LO(DATA_LO)) u_reg (
    .phi2      (phi2),
    .clr_n     (clr_all_n),
    .wr_hit    (wr_hit),
    .host_data (host_data),
    .sel       (sel)
  );

  bx_cas_steer #(.SEL_W(SEL_W), .CPG(CPG), .NOUT(NOUT)) u_steer (
    .sel        (sel),
    .ctl_cas_n  (ctl_cas_n),
    .bank_cas_n (bank_cas_n)
  );

  assign grp_led = sel;
endmodule

// File: rtl/bx_bank_ext_chk.sv
`timescale 1ns/1ps
module bx_bank_ext_chk #(
  parameter int SEL_W = 2,
  parameter int CPG   = 2,
  parameter int NOUT  = 8
) (
  input logic             phi2,
  input logic             rst_n,
  input logic             clr_all_n,
  input logic             wr_hit,
  input logic [SEL_W-1:0] new_sel,
  input logic [SEL_W-1:0] sel,
  input logic [SEL_W-1:0] grp_led,
  input logic [CPG-1:0]   ctl_cas_n,
  input logic [NOUT-1:0]  bank_cas_n
);
  // R1: a qualified write seen at one falling edge shows up by the next
  a_r1_write_loads: assert property (@(negedge phi2) disable iff (!clr_all_n)
    ($past(rst_n) && $past(clr_all_n) && $past(wr_hit)) |-> (sel == $past(new_sel)));

  // R4: no qualified write means no change
  a_r4_idle_holds: assert property (@(negedge phi2) disable iff (!clr_all_n)
    ($past(rst_n) && $past(clr_all_n) && !$past(wr_hit)) |-> $stable(sel));

  // R5: clear forces the visible group to zero
  a_r5_clear_zero: assert property (@(posedge phi2) disable iff (!rst_n)
    !clr_all_n |-> (grp_led == '0));

  // R6: first and last strobe of the selected pair follow the controller
  a_r6_first_path: assert property (@(posedge phi2) disable iff (!rst_n)
    bank_cas_n[int'(grp_led)*CPG] == ctl_cas_n[0]);
  a_r6_last_path: assert property (@(posedge phi2) disable iff (!rst_n)
    bank_cas_n[int'(grp_led)*CPG + CPG - 1] == ctl_cas_n[CPG-1]);

  // R7: never more active CAS lines than controller strobes
  a_r7_no_extra_cas: assert property (@(posedge phi2) disable iff (!rst_n)
    $countones(~bank_cas_n) == $countones(~ctl_cas_n));
endmodule

bind bx_bank_ext bx_bank_ext_chk #(.SEL_W(SEL_W), .CPG(CPG), .NOUT(NOUT)) chk_i (
  .phi2       (phi2),
  .rst_n      (rst_n),
  .clr_all_n  (clr_all_n),
  .wr_hit     (wr_hit),
  .new_sel    (SEL_W'(host_data >> DATA_LO)),
  .sel        (sel),
  .grp_led    (grp_led),
  .ctl_cas_n  (ctl_cas_n),
  .bank_cas_n (bank_cas_n)
);

// File: tb/bx_bank_ext_tb_top.sv
`timescale 1ns/1ps
module bx_bank_ext_tb_top;
  logic       phi2 = 1'b0;
  logic       rst_n = 1'b1;
  logic       compat_clr_n = 1'b1;
  logic       io_page_n = 1'b1;
  logic [7:0] host_addr = 8'h00;
  logic       host_rw = 1'b1;
  logic [7:0] host_data = 8'h00;
  logic [1:0] ctl_cas_n = 2'b11;
  logic [7:0] bank_cas_n;
  logic [1:0] grp_led;

  int total = 0;
  int fails = 0;
  int model_sel = 0;
  bit cmp_on = 1'b0;

  always #10 phi2 = ~phi2;  // 50 MHz

  bx_bank_ext dut_i (
    .phi2(phi2), .rst_n(rst_n), .compat_clr_n(compat_clr_n),
    .io_page_n(io_page_n), .host_addr(host_addr), .host_rw(host_rw),
    .host_data(host_data), .ctl_cas_n(ctl_cas_n),
    .bank_cas_n(bank_cas_n), .grp_led(grp_led)
  );

  // Behavioural reference: group number in an integer
  always @(negedge phi2 or negedge compat_clr_n or negedge rst_n) begin
    if (!rst_n || !compat_clr_n) model_sel = 0;
    else if (!io_page_n && !host_rw && (int'(host_addr) % 8) == 6)
      model_sel = (int'(host_data) / 8) % 4;
  end

  function automatic int exp_cas(int g, logic [1:0] c);
    int v = 0;
    for (int i = 0; i < 8; i++)
      v += ((i / 2 == g) ? int'(c[i % 2]) : 1) << i;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, mid low phase
  always @(negedge phi2) begin
    #5;
    if (cmp_on) begin
      check("R8 status vs model", int'(grp_led), model_sel);
      check("R6 strobes vs model", int'(bank_cas_n), exp_cas(model_sel, ctl_cas_n));
    end
  end

  task automatic bus_cycle(int addr, bit rw, int data, bit io_n);
    @(posedge phi2); #2;
    io_page_n = io_n; host_addr = 8'(addr); host_rw = rw; host_data = 8'(data);
    @(negedge phi2); #3;
    io_page_n = 1'b1; host_rw = 1'b1;
  endtask

  initial begin
    #5 rst_n = 1'b0;
    #40 rst_n = 1'b1;
    @(negedge phi2); #5;
    check("R9 reset group", int'(grp_led), 0);
    check("R9 reset strobes high", int'(bank_cas_n), 255);
    cmp_on = 1'b1;

    bus_cycle(8'h06, 1'b0, 8'h08, 1'b0); #2;
    check("R1 write offset 6 bit3", int'(grp_led), 1);
    bus_cycle(8'h0E, 1'b0, 8'h10, 1'b0); #2;
    check("R2 alias 0x0E", int'(grp_led), 2);
    bus_cycle(8'h16, 1'b0, 8'h08, 1'b0); #2;
    check("R2 alias 0x16", int'(grp_led), 1);
    bus_cycle(8'h1E, 1'b0, 8'h18, 1'b0); #2;
    check("R2 alias 0x1E", int'(grp_led), 3);
    bus_cycle(8'h86, 1'b0, 8'hE7, 1'b0); #2;
    check("R3 other data bits ignored", int'(grp_led), 0);
    bus_cycle(8'h06, 1'b0, 8'h10, 1'b0); #2;
    check("R3 bit4 to select bit 1", int'(grp_led), 2);

    bus_cycle(8'h06, 1'b1, 8'h18, 1'b0); #2;
    check("R4 read at offset 6", int'(grp_led), 2);
    bus_cycle(8'h05, 1'b0, 8'h18, 1'b0); #2;
    check("R4 write other offset", int'(grp_led), 2);
    bus_cycle(8'h06, 1'b0, 8'h18, 1'b1); #2;
    check("R4 page not selected", int'(grp_led), 2);

    bus_cycle(8'h06, 1'b0, 8'h18, 1'b0); #2;
    check("R1 load 3 before clear", int'(grp_led), 3);
    @(posedge phi2); #2 compat_clr_n = 1'b0; #1;
    check("R5 clear immediate", int'(grp_led), 0);
    bus_cycle(8'h06, 1'b0, 8'h18, 1'b0); #2;
    check("R5 write during clear", int'(grp_led), 0);
    @(posedge phi2); #2 compat_clr_n = 1'b1;
    @(negedge phi2); #6;
    check("R5 stays zero after release", int'(grp_led), 0);

    for (int g = 0; g < 4; g++) begin
      bus_cycle(8'h06, 1'b0, g * 8, 1'b0);
      for (int c = 0; c < 4; c++) begin
        @(posedge phi2); #2 ctl_cas_n = 2'(c); #2;
        check("R6 routing", int'(bank_cas_n), exp_cas(g, 2'(c)));
        check("R7 unselected high",
              int'(bank_cas_n | (8'h03 << (2 * g))), 255);
        check("R8 status", int'(grp_led), g);
      end
      @(posedge phi2); #2 ctl_cas_n = 2'b11;
    end

    @(posedge phi2); #2 rst_n = 1'b0; #1;
    check("R9 async reset", int'(grp_led), 0);
    check("R9 strobes idle", int'(bank_cas_n), 255);
    #20 rst_n = 1'b1;
    repeat (3) @(posedge phi2);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule